// File: doc/BRIEF.md
# Remappable Priority Interrupt Controller

This block collects interrupt requests into a 16-bit pending register, filters them through a 16-bit enable mask, and presents the vector address of the most urgent enabled request. Four core sources occupy fixed slots 0 to 3. Each peripheral source is routed to a slot chosen by a programmable level held per peripheral ID. All levels above the last distinct one fold into slot 15 and share its vector.

The processor writes the mask and the per-peripheral levels through simple write strobes. It services the vector shown on the outputs, and pulses `ack` to retire that slot. A mode input moves the whole vector table up by 0x10000 when the processor runs from external memory without booting.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending and mask registers are all zero, `vec_valid` is 0, and peripheral ID k holds level k.
- R2: A raw line that is high at a rising clock edge sets its slot in `pend`. The slot stays set until acknowledged.
- R3: Core lines 0..3 always map to slots 0..3: slot 0 is reset, 1 is power-down, 2 is loop/stack fault and 3 is debug kernel.
- R4: A peripheral whose level p is 0..10 maps to slot 4+p.
- R5: A peripheral whose level is 11 or higher maps to slot 15, and all such peripherals share vector 0x01E0.
- R6: Slots 2..15 take part in selection only when their mask bit is 1. Slots 0 and 1 take part regardless of the mask.
- R7: Among the slots taking part, the lowest-numbered one is selected and shown on `vec_idx`.
- R8: `vec_addr` equals `vec_idx` times 0x20. It is increased by 0x10000 while `noboot` is 1.
- R9: `ack` with `vec_valid` high clears the selected slot at the next edge. A source that is still high sets that slot again in the same edge, and setting wins.
- R10: `vec_valid` is 1 exactly when at least one slot takes part in selection. When it is 0, `vec_idx` is 0.
- R11: With `prio_we` high, `prio_wdata` replaces the level of peripheral `prio_id` at the next edge. An ID of 12 or above changes nothing. With `mask_we` high, `mask_wdata` replaces the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_core | input | 4 | Core request lines for fixed slots 0..3 |
| irq_periph | input | NUM_PERIPH | Peripheral request lines, indexed by ID |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 16 | New mask value |
| prio_we | input | 1 | Level write strobe |
| prio_id | input | ID_W | Peripheral ID whose level is written |
| prio_wdata | input | PRIO_W | New level |
| ack | input | 1 | Retire the currently selected slot |
| noboot | input | 1 | Offset the vector table by 0x10000 |
| pend | output | 16 | Pending register |
| vec_valid | output | 1 | A selectable request exists |
| vec_idx | output | 4 | Selected slot |
| vec_addr | output | ADDR_W | Vector address of the selected slot |

## Verification
The bench builds the block with its defaults: twelve peripherals, 4-bit levels and 24-bit vector addresses. With 4-bit levels, every level from 0 to 15 can be written. This reaches both the linear slots and the folding of levels 11..15 onto slot 15. Twelve peripherals together with a 4-bit ID leave IDs 12..15 free, so writes to IDs that do not exist are exercised. Random traffic with several peripherals parked on slot 15 drives acknowledges against sources that are still asserted.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_PERIPH  = 12,
  parameter int PRIO_W      = 4,
  parameter int ADDR_W      = 24,
  parameter int VEC_SHIFT   = 5,
  parameter int NOBOOT_BASE = 32'h10000,
  localparam int ID_W       = $clog2(NUM_PERIPH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            irq_core,
  input  logic [NUM_PERIPH-1:0] irq_periph,
  input  logic                  mask_we,
  input  logic [15:0]           mask_wdata,
  input  logic                  prio_we,
  input  logic [ID_W-1:0]       prio_id,
  input  logic [PRIO_W-1:0]     prio_wdata,
  input  logic                  ack,
  input  logic                  noboot,
  output logic [15:0]           pend,
  output logic                  vec_valid,
  output logic [3:0]            vec_idx,
  output logic [ADDR_W-1:0]     vec_addr
);
  localparam int LAST_LVL = 10;
  localparam logic [15:0] NMI_SLOTS = 16'h0003;

  logic [15:0]       pend_q, mask_q, set_v, eff, clear_v;
  logic [PRIO_W-1:0] prio_q [NUM_PERIPH];
  logic [3:0]        sel;

  function automatic logic [3:0] slot_of(input logic [PRIO_W-1:0] p);
    return (32'(p) > LAST_LVL) ? 4'd15 : 4'(p) + 4'd4;
  endfunction

  always_comb begin
    set_v = {12'b0, irq_core};
    for (int k = 0; k < NUM_PERIPH; k++)
      if (irq_periph[k]) set_v[slot_of(prio_q[k])] = 1'b1;
  end

  assign eff = pend_q & (mask_q | NMI_SLOTS);

  always_comb begin
    sel = 4'd0;
    for (int b = 15; b >= 0; b--)
      if (eff[b]) sel = 4'(b);
  end

  assign vec_valid = |eff;
  assign vec_idx   = sel;
  assign vec_addr  = (ADDR_W'(sel) << VEC_SHIFT) + (noboot ? ADDR_W'(NOBOOT_BASE) : '0);
  assign pend      = pend_q;
  assign clear_v   = (ack && vec_valid) ? (16'b1 << sel) : 16'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clear_v) | set_v;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  for (genvar k = 0; k < NUM_PERIPH; k++) begin : g_prio
    always_ff @(posedge clk) begin
      if (!rst_n) prio_q[k] <= PRIO_W'(k);
      else if (prio_we && prio_id == ID_W'(k)) prio_q[k] <= prio_wdata;
    end

    // R5
    fold_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_periph[k] && 32'(prio_q[k]) > LAST_LVL) |=> pend_q[15]);
  end

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R3
  core_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_core[3] |=> pend_q[3]);

  // R6
  nmi_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[0] |-> (vec_valid && vec_idx == 4'd0));

  // R7
  sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (pend_q[vec_idx] && (mask_q[vec_idx] || vec_idx < 4'd2)));

  // R8
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec_addr[VEC_SHIFT-1:0] == '0);

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && vec_valid && !set_v[sel]) |=> !pend_q[$past(sel)]);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int NP = 12;
  logic clk = 0, rst_n = 0;
  logic [3:0]  irq_core = 0;
  logic [NP-1:0] irq_periph = 0;
  logic mask_we = 0, prio_we = 0, ack = 0, noboot = 0;
  logic [15:0] mask_wdata = 0;
  logic [3:0]  prio_id = 0, prio_wdata = 0;
  logic [15:0] pend;
  logic vec_valid;
  logic [3:0] vec_idx;
  logic [23:0] vec_addr;

  int errors = 0, checks = 0;
  logic [15:0] m_pend, m_mask;
  logic [3:0]  m_prio [NP];

  always #10 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (.clk, .rst_n, .irq_core, .irq_periph, .mask_we, .mask_wdata,
    .prio_we, .prio_id, .prio_wdata, .ack, .noboot, .pend, .vec_valid, .vec_idx, .vec_addr);

  function automatic logic [15:0] m_eff();
    return m_pend & (m_mask | 16'h0003);
  endfunction

  function automatic logic [3:0] m_sel();
    logic [15:0] e = m_eff();
    for (int b = 0; b < 16; b++) if (e[b]) return 4'(b);
    return 4'd0;
  endfunction

  function automatic logic [3:0] m_slot(input logic [3:0] p);
    if (p >= 4'd11) return 4'd15;
    return p + 4'd4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp(input string tag);
    logic [23:0] ea;
    ea = 24'(m_sel()) * 24'h20 + (noboot ? 24'h10000 : 24'h0);
    chk({tag, " pend"}, 32'(pend), 32'(m_pend));
    chk({tag, " valid"}, 32'(vec_valid), 32'(|m_eff()));
    chk({tag, " idx"}, 32'(vec_idx), 32'(m_sel()));
    chk({tag, " addr"}, 32'(vec_addr), 32'(ea));
  endtask

  task automatic cycle(input string tag);
    logic [15:0] s, c;
    @(posedge clk);
    s = {12'b0, irq_core};
    for (int k = 0; k < NP; k++) if (irq_periph[k]) s[m_slot(m_prio[k])] = 1'b1;
    c = (ack && |m_eff()) ? (16'b1 << m_sel()) : 16'b0;
    m_pend = (m_pend & ~c) | s;
    if (mask_we) m_mask = mask_wdata;
    if (prio_we && prio_id < 4'(NP)) m_prio[prio_id] = prio_wdata;
    @(negedge clk);
    cmp(tag);
    irq_core = 0; irq_periph = 0; mask_we = 0; prio_we = 0; ack = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    m_pend = 0; m_mask = 0;
    for (int k = 0; k < NP; k++) m_prio[k] = 4'(k);
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp("R1 reset");
    // R6 R10: masked slot 2 pends but is not selectable
    irq_core = 4'b0100; cycle("R6 R10 masked slot2");
    // R6: power-down slot ignores mask
    irq_core = 4'b0010; cycle("R6 nmi slot1");
    ack = 1; cycle("R9 ack slot1");
    // R3 R7: unmask all; slot 2 then slot 3 order
    mask_we = 1; mask_wdata = 16'hFFFF; irq_core = 4'b1000; cycle("R11 R3 mask write");
    ack = 1; cycle("R7 R9 ack slot2");
    ack = 1; cycle("R9 ack slot3");
    // R4 R11: peripheral 5 to level 0 -> slot 4
    prio_we = 1; prio_id = 4'd5; prio_wdata = 4'd0; cycle("R11 prio write");
    irq_periph[5] = 1; cycle("R4 level0 slot4");
    ack = 1; cycle("R9 ack slot4");
    // R5: default level 11 of ID 11 -> slot 15, and level 13 on ID 2
    prio_we = 1; prio_id = 4'd2; prio_wdata = 4'd13; cycle("R11 prio fold");
    irq_periph[11] = 1; irq_periph[2] = 1; cycle("R5 shared slot15");
    // R9: ack while ID 11 still high re-latches
    irq_periph[11] = 1; ack = 1; cycle("R9 relatch");
    // R8 noboot offset
    noboot = 1; cycle("R8 noboot offset");
    ack = 1; cycle("R9 ack slot15");
    noboot = 0;
    // R11: out-of-range ID ignored
    prio_we = 1; prio_id = 4'd13; prio_wdata = 4'd0; cycle("R11 bad id");
    irq_periph[3] = 1; cycle("R11 R4 id3 level3 slot7");
    ack = 1; cycle("R9 ack slot7");
    // R2: held pending with partial mask
    mask_we = 1; mask_wdata = 16'h00F0; irq_periph[9] = 1; cycle("R2 R6 masked pend");
    cycle("R2 hold");
    for (int i = 0; i < 3000; i++) begin
      for (int k = 0; k < NP; k++) irq_periph[k] = ($urandom % 12) == 0;
      irq_core = 4'($urandom) & (($urandom % 6) == 0 ? 4'hF : 4'hC);
      ack = ($urandom % 3) == 0;
      mask_we = ($urandom % 25) == 0; mask_wdata = 16'($urandom);
      prio_we = ($urandom % 20) == 0; prio_id = 4'($urandom); prio_wdata = 4'($urandom);
      noboot = ($urandom % 8) == 0;
      cycle("R2-R11 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule